// File: doc/BRIEF.md
# Scripted SPI Transaction Sequencer

This block runs short byte-code scripts that drive an SPI master (mode 0, most significant bit first) and a bank of general-purpose output pins such as chip selects and data/command lines. Scripts sit in a byte-wide program memory. Each of the 16 request inputs, when pulsed, marks one script as pending. Whenever the engine is idle it launches the lowest-numbered pending script. The start address of script `i` is the program byte stored at address `i`.

Pin opcodes and descriptor opcodes run back to back. Transfer opcodes hold the script until the current byte has been fully clocked. The engine reads and writes data memory through a descriptor, which is a pair of bytes in data memory: a buffer address followed by a byte count. A receive opcode stores every incoming byte at that address. A block-send opcode streams bytes from that address out over SPI.

Top module: `spi_script_seq`

## Requirements
- R1: After reset, every pin output is 1, `spi_sclk_o` is 0, no request is pending and `dmem_we_o` is 0.
- R2: A request pulse marks its script pending, and a script starts only while no script runs. When several are pending, the lowest index launches first. Its pending mark is cleared at launch. The start address is the program byte at address equal to the index.
- R3: Opcode 1 (operand p) drives pin p to 1 and opcode 2 (operand p) drives pin p to 0. Neither produces SPI traffic. An operand of `NUM_PINS` or more changes no pin.
- R4: Opcode 3 (operand b) sends b. The script continues only after the eighth falling SCLK edge. Pins do not change while a byte is in flight.
- R5: Opcode 8 (operand k) loads the active descriptor from data memory. The buffer address is the byte at `DESC_BASE+2k` and the count is the byte at `DESC_BASE+2k+1`.
- R6: Opcode 6 sends 0x00 once per counted byte and writes each received byte to the buffer address, moving upward. With a count of zero it sends nothing and writes nothing.
- R7: Opcode 4 (operand k) loads descriptor k in the same way as R5. It then sends the counted bytes from the buffer address in ascending order. Received bytes are dropped and data memory is not written.
- R8: Opcode 9 waits while a transfer is in flight and then advances. Opcode 11 ends the script and returns to idle. Codes 0, 5, 7, 10 and 12 to 255 are one-byte no-ops.
- R9: SCLK idles low. Each SCLK high and low phase lasts `SCLK_HALF` clock cycles. MOSI changes on falling edges and MISO is sampled on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ | One-cycle script request pulses |
| prog_addr_o | output | PROG_AW | Program memory address; the data returns one cycle later |
| prog_data_i | input | 8 | Program memory read data |
| dmem_addr_o | output | DATA_AW | Data memory address |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_wdata_o | output | 8 | Data memory write data |
| dmem_rdata_i | input | 8 | Data memory read data, one cycle after the address |
| spi_sclk_o | output | 1 | SPI clock |
| spi_mosi_o | output | 1 | SPI data out |
| spi_miso_i | input | 1 | SPI data in |
| pin_o | output | NUM_PINS | General-purpose output pins |

## Verification
The embedded assertions check these rules on every cycle:
- Pins stay frozen while a byte is in flight.
- The shifter is never started while it is busy, and SCLK sits low whenever it is idle.
- A launch happens only with a request pending, and it clears that request's mark.
- Data memory is written only during a receive with a nonzero count.

Only the bench scenarios can show the rest:
- the launch order among several requests;
- the exact bytes on MOSI and the pin state during each byte;
- the received bytes landing at the descriptor address;
- no-op opcodes, out-of-range pin indices and zero counts being passed over without side effects.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam logic [7:0] OP_PIN_HI   = 8'd1;
  localparam logic [7:0] OP_PIN_LO   = 8'd2;
  localparam logic [7:0] OP_SEND_IMM = 8'd3;
  localparam logic [7:0] OP_SEND_BLK = 8'd4;
  localparam logic [7:0] OP_RECV_BLK = 8'd6;
  localparam logic [7:0] OP_SEL_DESC = 8'd8;
  localparam logic [7:0] OP_DRAIN    = 8'd9;
  localparam logic [7:0] OP_STOP     = 8'd11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_VEC, ST_OP, ST_ARG, ST_DSC_A, ST_DSC_C,
    ST_RECV, ST_BLK_RD, ST_BLK_GO, ST_XFER
  } seq_state_e;
endpackage

// File: rtl/spi_seq_arb.sv
module spi_seq_arb #(
  parameter int NUM_REQ = 16,
  parameter int REQ_IW  = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               launch_i,
  output logic               grant_vld_o,
  output logic [REQ_IW-1:0]  grant_idx_o
);
  logic [NUM_REQ-1:0] pend_q, pend_n, clr_mask;

  always_comb begin
    grant_idx_o = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (pend_q[i]) grant_idx_o = REQ_IW'(i);
    end
    grant_vld_o = |pend_q;
  end

  always_comb begin
    clr_mask = '0;
    if (launch_i) clr_mask[grant_idx_o] = 1'b1;
    pend_n = (pend_q & ~clr_mask) | req_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_n;
  end

  AST_LAUNCH_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_ni)
    launch_i |-> (pend_q != '0)); // R2
  AST_LAUNCH_CLEARS_MARK: assert property (@(posedge clk) disable iff (!rst_ni)
    (launch_i && !req_i[grant_idx_o]) |=> !pend_q[$past(grant_idx_o)]); // R2
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(SCLK_HALF - 1);

  logic          busy_q, busy_n, sclk_q, sclk_n;
  logic [7:0]    tx_q, tx_n, rx_q, rx_n;
  logic [2:0]    bit_q, bit_n;
  logic [CW-1:0] div_q, div_n;
  logic          tick;

  assign tick   = (div_q == DIV_LAST);
  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = busy_q & sclk_q & tick & (bit_q == 3'd7);

  always_comb begin
    busy_n = busy_q;
    sclk_n = sclk_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    bit_n  = bit_q;
    div_n  = div_q;
    if (start_i && !busy_q) begin
      busy_n = 1'b1;
      sclk_n = 1'b0;
      tx_n   = tx_i;
      bit_n  = 3'd0;
      div_n  = '0;
    end else if (busy_q) begin
      if (tick) begin
        div_n = '0;
        if (!sclk_q) begin
          sclk_n = 1'b1;
          rx_n   = {rx_q[6:0], miso_i};
        end else begin
          sclk_n = 1'b0;
          tx_n   = {tx_q[6:0], 1'b0};
          bit_n  = bit_q + 3'd1;
          if (bit_q == 3'd7) busy_n = 1'b0;
        end
      end else begin
        div_n = div_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_n;
      sclk_q <= sclk_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      bit_q  <= bit_n;
      div_q  <= div_n;
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |-> !busy_q); // R4
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy_q |-> !sclk_q); // R9
endmodule

// File: rtl/spi_seq_core.sv
module spi_seq_core
  import spi_seq_pkg::*;
#(
  parameter int          PROG_AW   = 8,
  parameter int          DATA_AW   = 8,
  parameter int          NUM_PINS  = 8,
  parameter int          REQ_IW    = 4,
  parameter int          DESC_BASE = 240,
  parameter logic [31:0] PIN_RESET = 32'hFFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                grant_vld_i,
  input  logic [REQ_IW-1:0]   grant_idx_i,
  output logic                launch_o,
  output logic [PROG_AW-1:0]  prog_addr_o,
  input  logic [7:0]          prog_data_i,
  output logic [DATA_AW-1:0]  dmem_addr_o,
  output logic                dmem_we_o,
  output logic [7:0]          dmem_wdata_o,
  input  logic [7:0]          dmem_rdata_i,
  output logic                xfer_start_o,
  output logic [7:0]          xfer_data_o,
  input  logic                xfer_busy_i,
  input  logic                xfer_done_i,
  input  logic [7:0]          xfer_rx_i,
  output logic [NUM_PINS-1:0] pin_o
);
  localparam int PIN_IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [DATA_AW-1:0] DBASE = DATA_AW'(DESC_BASE);
  localparam logic [PROG_AW-1:0] ONE   = PROG_AW'(1);
  localparam logic [PROG_AW-1:0] TWO   = PROG_AW'(2);

  seq_state_e          state_q, state_n;
  logic [PROG_AW-1:0]  pc_q, pc_n;
  logic [7:0]          op_q, op_n, dsc_q, dsc_n, cnt_q, cnt_n;
  logic [DATA_AW-1:0]  badr_q, badr_n;
  logic [NUM_PINS-1:0] pins_q, pins_n;
  logic                pin_ok;

  assign pin_o  = pins_q;
  assign pin_ok = (prog_data_i < 8'(NUM_PINS));

  always_comb begin
    state_n      = state_q;
    pc_n         = pc_q;
    prog_addr_o  = pc_q;
    op_n         = op_q;
    dsc_n        = dsc_q;
    badr_n       = badr_q;
    cnt_n        = cnt_q;
    pins_n       = pins_q;
    launch_o     = 1'b0;
    dmem_addr_o  = badr_q;
    dmem_we_o    = 1'b0;
    dmem_wdata_o = xfer_rx_i;
    xfer_start_o = 1'b0;
    xfer_data_o  = 8'h00;
    unique case (state_q)
      ST_IDLE: begin
        if (grant_vld_i) begin
          launch_o    = 1'b1;
          prog_addr_o = PROG_AW'(grant_idx_i);
          state_n     = ST_VEC;
        end
      end
      ST_VEC: begin
        pc_n        = PROG_AW'(prog_data_i);
        prog_addr_o = PROG_AW'(prog_data_i);
        state_n     = ST_OP;
      end
      ST_OP: begin
        op_n = prog_data_i;
        case (prog_data_i)
          OP_PIN_HI, OP_PIN_LO, OP_SEND_IMM, OP_SEND_BLK, OP_SEL_DESC: begin
            prog_addr_o = pc_q + ONE;
            state_n     = ST_ARG;
          end
          OP_RECV_BLK: state_n = ST_RECV;
          OP_DRAIN: begin
            if (!xfer_busy_i) begin
              pc_n        = pc_q + ONE;
              prog_addr_o = pc_q + ONE;
            end
          end
          OP_STOP: state_n = ST_IDLE;
          default: begin
            pc_n        = pc_q + ONE;
            prog_addr_o = pc_q + ONE;
          end
        endcase
      end
      ST_ARG: begin
        if (op_q == OP_PIN_HI || op_q == OP_PIN_LO) begin
          if (pin_ok) pins_n[prog_data_i[PIN_IW-1:0]] = (op_q == OP_PIN_HI);
          pc_n        = pc_q + TWO;
          prog_addr_o = pc_q + TWO;
          state_n     = ST_OP;
        end else if (op_q == OP_SEND_IMM) begin
          xfer_start_o = 1'b1;
          xfer_data_o  = prog_data_i;
          state_n      = ST_XFER;
        end else begin
          dsc_n       = prog_data_i;
          dmem_addr_o = DBASE + DATA_AW'({prog_data_i, 1'b0});
          state_n     = ST_DSC_A;
        end
      end
      ST_DSC_A: begin
        badr_n      = DATA_AW'(dmem_rdata_i);
        dmem_addr_o = DBASE + DATA_AW'({dsc_q, 1'b1});
        state_n     = ST_DSC_C;
      end
      ST_DSC_C: begin
        cnt_n = dmem_rdata_i;
        if (op_q == OP_SEND_BLK) begin
          state_n = ST_BLK_RD;
        end else begin
          pc_n        = pc_q + TWO;
          prog_addr_o = pc_q + TWO;
          state_n     = ST_OP;
        end
      end
      ST_BLK_RD: begin
        if (cnt_q == 8'd0) begin
          pc_n        = pc_q + TWO;
          prog_addr_o = pc_q + TWO;
          state_n     = ST_OP;
        end else begin
          state_n = ST_BLK_GO;
        end
      end
      ST_BLK_GO: begin
        xfer_start_o = 1'b1;
        xfer_data_o  = dmem_rdata_i;
        badr_n       = badr_q + DATA_AW'(1);
        cnt_n        = cnt_q - 8'd1;
        state_n      = ST_XFER;
      end
      ST_RECV: begin
        if (cnt_q == 8'd0) begin
          pc_n        = pc_q + ONE;
          prog_addr_o = pc_q + ONE;
          state_n     = ST_OP;
        end else begin
          xfer_start_o = 1'b1;
          xfer_data_o  = 8'h00;
          state_n      = ST_XFER;
        end
      end
      ST_XFER: begin
        if (xfer_done_i) begin
          if (op_q == OP_SEND_IMM) begin
            pc_n        = pc_q + TWO;
            prog_addr_o = pc_q + TWO;
            state_n     = ST_OP;
          end else if (op_q == OP_SEND_BLK) begin
            state_n = ST_BLK_RD;
          end else begin
            dmem_we_o = 1'b1;
            badr_n    = badr_q + DATA_AW'(1);
            cnt_n     = cnt_q - 8'd1;
            state_n   = ST_RECV;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      op_q    <= '0;
      dsc_q   <= '0;
      badr_q  <= '0;
      cnt_q   <= '0;
      pins_q  <= PIN_RESET[NUM_PINS-1:0];
    end else begin
      state_q <= state_n;
      pc_q    <= pc_n;
      op_q    <= op_n;
      dsc_q   <= dsc_n;
      badr_q  <= badr_n;
      cnt_q   <= cnt_n;
      pins_q  <= pins_n;
    end
  end

  AST_PINS_FROZEN_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer_busy_i |=> $stable(pins_q)); // R4
  AST_XFER_STATE_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_XFER) |-> xfer_busy_i); // R4
  AST_WRITE_ONLY_RECV: assert property (@(posedge clk) disable iff (!rst_ni)
    dmem_we_o |-> (op_q == OP_RECV_BLK && cnt_q != 8'd0)); // R6
endmodule

// File: rtl/spi_script_seq.sv
module spi_script_seq #(
  parameter int          NUM_REQ   = 16,
  parameter int          NUM_PINS  = 8,
  parameter int          PROG_AW   = 8,
  parameter int          DATA_AW   = 8,
  parameter int          DESC_BASE = 240,
  parameter int          SCLK_HALF = 2,
  parameter logic [31:0] PIN_RESET = 32'hFFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REQ-1:0]  req_i,
  output logic [PROG_AW-1:0]  prog_addr_o,
  input  logic [7:0]          prog_data_i,
  output logic [DATA_AW-1:0]  dmem_addr_o,
  output logic                dmem_we_o,
  output logic [7:0]          dmem_wdata_o,
  input  logic [7:0]          dmem_rdata_i,
  output logic                spi_sclk_o,
  output logic                spi_mosi_o,
  input  logic                spi_miso_i,
  output logic [NUM_PINS-1:0] pin_o
);
  localparam int REQ_IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              grant_vld, launch;
  logic [REQ_IW-1:0] grant_idx;
  logic              x_start, x_busy, x_done;
  logic [7:0]        x_tx, x_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  spi_seq_arb #(.NUM_REQ(NUM_REQ), .REQ_IW(REQ_IW)) u_arb (
    .clk(clk), .rst_ni(rst_i_n), .req_i(req_i), .launch_i(launch),
    .grant_vld_o(grant_vld), .grant_idx_o(grant_idx));

  spi_seq_core #(
    .PROG_AW(PROG_AW), .DATA_AW(DATA_AW), .NUM_PINS(NUM_PINS),
    .REQ_IW(REQ_IW), .DESC_BASE(DESC_BASE), .PIN_RESET(PIN_RESET)
  ) u_core (
    .clk(clk), .rst_ni(rst_i_n),
    .grant_vld_i(grant_vld), .grant_idx_i(grant_idx), .launch_o(launch),
    .prog_addr_o(prog_addr_o), .prog_data_i(prog_data_i),
    .dmem_addr_o(dmem_addr_o), .dmem_we_o(dmem_we_o),
    .dmem_wdata_o(dmem_wdata_o), .dmem_rdata_i(dmem_rdata_i),
    .xfer_start_o(x_start), .xfer_data_o(x_tx), .xfer_busy_i(x_busy),
    .xfer_done_i(x_done), .xfer_rx_i(x_rx), .pin_o(pin_o));

  spi_seq_shifter #(.SCLK_HALF(SCLK_HALF)) u_shift (
    .clk(clk), .rst_ni(rst_i_n), .start_i(x_start), .tx_i(x_tx),
    .busy_o(x_busy), .done_o(x_done), .rx_o(x_rx),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .miso_i(spi_miso_i));
endmodule

// File: tb/sim_spi_script_seq.sv
`timescale 1ns/1ps
module sim_spi_script_seq;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic [7:0]  prog_addr, prog_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, sclk, mosi, miso;
  logic [7:0]  pins;

  logic [7:0] pmem [256];
  logic [7:0] dmem [256];

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { logic [7:0] b; logic [7:0] g; string r; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  spi_script_seq #(.SCLK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .prog_addr_o(prog_addr), .prog_data_i(prog_data),
    .dmem_addr_o(dmem_addr), .dmem_we_o(dmem_we), .dmem_wdata_o(dmem_wdata),
    .dmem_rdata_i(dmem_rdata), .spi_sclk_o(sclk), .spi_mosi_o(mosi),
    .spi_miso_i(miso), .pin_o(pins));

  always @(posedge clk) begin
    prog_data  <= pmem[prog_addr];
    dmem_rdata <= dmem[dmem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
  end

  function automatic logic [7:0] slave_byte(int n);
    return 8'h5C + 8'(n * 19);
  endfunction

  // slave: byte n on MISO, next bit after each falling edge
  int         slv_n = 0;
  logic [2:0] slv_bit = 3'd0;
  logic [7:0] slv_cur;
  assign slv_cur = slave_byte(slv_n);
  assign miso    = slv_cur[3'd7 - slv_bit];
  always @(negedge sclk) begin
    if (rst_n) begin
      if (slv_bit == 3'd7) begin
        slv_bit <= 3'd0;
        slv_n   <= slv_n + 1;
      end else begin
        slv_bit <= slv_bit + 3'd1;
      end
    end
  end

  task automatic check(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic expect_byte(logic [7:0] b, logic [7:0] g, string r);
    exp_t e;
    e.b = b; e.g = g; e.r = r;
    exp_q.push_back(e);
  endtask

  task automatic pulse(logic [15:0] mask);
    @(negedge clk) req = mask;
    @(negedge clk) req = '0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  // monitor: assemble MOSI bytes on rising SCLK and compare
  initial begin
    logic [7:0] sh;
    exp_t e;
    forever begin
      for (int i = 0; i < 8; i++) begin
        @(posedge sclk);
        sh = {sh[6:0], mosi};
      end
      if (exp_q.size() == 0) begin
        check("R2", "unexpected MOSI byte", {24'h0, sh}, 32'hFFFF_FFFF);
      end else begin
        e = exp_q.pop_front();
        check(e.r, "MOSI byte", {24'h0, sh}, {24'h0, e.b});
        check(e.r, "pins during byte", {24'h0, pins}, {24'h0, e.g});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi;
    for (int i = 0; i < 256; i++) begin
      pmem[i] <= 8'h0B;
      dmem[i] <= 8'h00;
    end
    #1;
    // vectors
    pmem[1] <= 8'h20; pmem[3] <= 8'h30; pmem[5] <= 8'h50; pmem[15] <= 8'h70;
    // script 1: send 3C, end
    pmem[8'h20] <= 8'h03; pmem[8'h21] <= 8'h3C; pmem[8'h22] <= 8'h0B;
    // script 3: pin0 low, send 9A, desc0, receive, pin0 high, end
    pmem[8'h30] <= 8'h02; pmem[8'h31] <= 8'h00; pmem[8'h32] <= 8'h03;
    pmem[8'h33] <= 8'h9A; pmem[8'h34] <= 8'h08; pmem[8'h35] <= 8'h00;
    pmem[8'h36] <= 8'h06; pmem[8'h37] <= 8'h01; pmem[8'h38] <= 8'h00;
    pmem[8'h39] <= 8'h0B;
    // script 5: block desc1, drain, no-ops 0A 00 EE 07 05, pin9 high, pin2 low, end
    pmem[8'h50] <= 8'h04; pmem[8'h51] <= 8'h01; pmem[8'h52] <= 8'h09;
    pmem[8'h53] <= 8'h0A; pmem[8'h54] <= 8'h00; pmem[8'h55] <= 8'hEE;
    pmem[8'h56] <= 8'h07; pmem[8'h57] <= 8'h05; pmem[8'h58] <= 8'h01;
    pmem[8'h59] <= 8'h09; pmem[8'h5A] <= 8'h02; pmem[8'h5B] <= 8'h02;
    pmem[8'h5C] <= 8'h0B;
    // script 15: desc2 (count 0), receive, send 77, end
    pmem[8'h70] <= 8'h08; pmem[8'h71] <= 8'h02; pmem[8'h72] <= 8'h06;
    pmem[8'h73] <= 8'h03; pmem[8'h74] <= 8'h77; pmem[8'h75] <= 8'h0B;
    // descriptors at 0xF0
    dmem[8'hF0] <= 8'h80; dmem[8'hF1] <= 8'h03;
    dmem[8'hF2] <= 8'h40; dmem[8'hF3] <= 8'h04;
    dmem[8'hF4] <= 8'h90; dmem[8'hF5] <= 8'h00;
    dmem[8'h40] <= 8'h11; dmem[8'h41] <= 8'h22;
    dmem[8'h42] <= 8'h33; dmem[8'h43] <= 8'h44;
    dmem[8'h83] <= 8'hCD; dmem[8'h90] <= 8'hAB;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "pins after reset", {24'h0, pins}, 32'hFF);
    check("R1", "sclk after reset", {31'h0, sclk}, 32'h0);
    check("R1", "write enable after reset", {31'h0, dmem_we}, 32'h0);
    repeat (20) @(negedge clk);
    check("R1", "no traffic without request", {31'h0, sclk}, 32'h0);

    // R3 R4 R5 R6, request 15 raised while script 3 runs (R2)
    expect_byte(8'h9A, 8'hFE, "R4");
    expect_byte(8'h00, 8'hFE, "R6");
    expect_byte(8'h00, 8'hFE, "R6");
    expect_byte(8'h00, 8'hFE, "R6");
    expect_byte(8'h77, 8'hFF, "R2");
    pulse(16'h0008);
    repeat (12) @(negedge clk);
    pulse(16'h8000);
    wait_drain();
    check("R5", "rx byte 0", {24'h0, dmem[8'h80]}, {24'h0, slave_byte(1)});
    check("R6", "rx byte 1", {24'h0, dmem[8'h81]}, {24'h0, slave_byte(2)});
    check("R6", "rx byte 2", {24'h0, dmem[8'h82]}, {24'h0, slave_byte(3)});
    check("R6", "past count untouched", {24'h0, dmem[8'h83]}, 32'hCD);
    check("R6", "zero count untouched", {24'h0, dmem[8'h90]}, 32'hAB);
    check("R3", "pin0 released", {24'h0, pins}, 32'hFF);

    // R2 priority: 1 and 5 together, 1 first; R7 block; R8 no-ops; R3 range
    expect_byte(8'h3C, 8'hFF, "R2");
    expect_byte(8'h11, 8'hFF, "R7");
    expect_byte(8'h22, 8'hFF, "R7");
    expect_byte(8'h33, 8'hFF, "R7");
    expect_byte(8'h44, 8'hFF, "R7");
    pulse(16'h0022);
    wait_drain();
    check("R8", "pins after no-ops and pin ops", {24'h0, pins}, 32'hFB);
    check("R3", "out-of-range pin ignored", {31'h0, pins[1]}, 32'h1);
    check("R7", "block source kept 0", {24'h0, dmem[8'h40]}, 32'h11);
    check("R7", "block source kept 3", {24'h0, dmem[8'h43]}, 32'h44);
    check("R7", "no write to rx area", {24'h0, dmem[8'h83]}, 32'hCD);

    // R9 SCLK phase length
    expect_byte(8'h3C, 8'hFB, "R9");
    pulse(16'h0002);
    @(posedge sclk);
    @(negedge clk);
    hi = 0;
    while (sclk) begin
      hi++;
      @(negedge clk);
    end
    check("R9", "sclk high cycles", hi, HALF);
    hi = 0;
    while (!sclk) begin
      hi++;
      @(negedge clk);
    end
    check("R9", "sclk low cycles", hi, HALF);
    wait_drain();
    check("R8", "queue drained", exp_q.size(), 0);
    check("R9", "sclk idle low", {31'h0, sclk}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule